// File: doc/BRIEF.md
# Dual-CPU Mailbox Interrupt Controller

This block sits between a main (host) CPU and a coprocessor and lets each side interrupt the other and leave it a short message. Each side owns a write port with a small register window: a control register that raises an interrupt toward the other side and carries a 4-bit message, a write-1-to-set enable register, and a write-1-to-clear disable register that also acknowledges pending interrupts. Each side sees a live flag byte that shows its pending interrupts and the message the other side left.

Interrupt raises are sticky: a pending flag, once set, stays set until the receiving side acknowledges it. Each interrupt line is the OR of the pending flags masked by the enables. Three event inputs (a timer tick and a DMA-done pulse for the coprocessor, a character-conversion pulse for the host) set their own pending flags. The host also writes the coprocessor's 16-bit reset, NMI and IRQ vectors, and the coprocessor writes two alternate 16-bit vectors for the host and selects, through its control register, whether the host should take its IRQ or NMI from them.

Top module: `mbx_irq_top`

## Requirements
- R1: After reset every flag bit, every interrupt output and every vector output is 0.
- R2: A host write to address 0 puts data bits 3:0 into `c_flags[3:0]`; data bit 7 sets the coprocessor IRQ pending flag (`c_flags[7]`) and data bit 4 sets the coprocessor NMI pending flag (`c_flags[4]`); a 0 in those bits changes nothing.
- R3: A coprocessor write to address 0 puts data bits 3:0 into `h_flags[3:0]`, copies data bit 6 (alternate IRQ vector select) to `h_flags[6]` and data bit 4 (alternate NMI vector select) to `h_flags[4]`, and data bit 7 sets the host IRQ pending flag (`h_flags[7]`).
- R4: A pending flag stays set through any number of cycles and writes until the receiving side writes a 1 to the matching bit of its disable register (address 2).
- R5: A 1 written to a disable-register bit clears both the enable and the pending flag of that bit; if a raise or event for the same bit arrives in the same cycle, the pending flag ends up set.
- R6: Writing address 1 sets the enable bits written as 1 and leaves the others; only host bits 7 and 5 and coprocessor bits 7, 6, 5 and 4 exist, other bits are ignored.
- R7: `h_irq` is high exactly when host bit 7 or 5 is both pending and enabled; `c_irq` likewise for coprocessor bits 7, 6, 5; `c_nmi` for coprocessor bit 4.
- R8: A high `timer_evt` sets `c_flags[6]`, `dma_done_evt` sets `c_flags[5]`, `chr_conv_evt` sets `h_flags[5]`, each in the cycle after.
- R9: Host addresses 3..8 write, low byte first, the coprocessor reset, NMI and IRQ vectors; coprocessor addresses 3..6 write the host's alternate NMI and then IRQ vector; every write appears on its vector output one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 4 | Host register address |
| h_wdata | input | 8 | Host write data |
| c_we | input | 1 | Coprocessor write strobe |
| c_addr | input | 4 | Coprocessor register address |
| c_wdata | input | 8 | Coprocessor write data |
| chr_conv_evt | input | 1 | Character-conversion event toward the host |
| timer_evt | input | 1 | Timer event toward the coprocessor |
| dma_done_evt | input | 1 | DMA completion event toward the coprocessor |
| h_flags | output | 8 | Host flag byte |
| c_flags | output | 8 | Coprocessor flag byte |
| h_irq | output | 1 | Interrupt request to the host |
| c_irq | output | 1 | Interrupt request to the coprocessor |
| c_nmi | output | 1 | Non-maskable request to the coprocessor |
| h_alt_nmi_vec | output | 16 | Host alternate NMI vector |
| h_alt_irq_vec | output | 16 | Host alternate IRQ vector |
| c_rst_vec | output | 16 | Coprocessor reset vector |
| c_nmi_vec | output | 16 | Coprocessor NMI vector |
| c_irq_vec | output | 16 | Coprocessor IRQ vector |

## Verification
The hardest case is a raise and an acknowledge of the same flag landing in the same cycle from the two independent write ports, optionally with an event pulse on top. The bench drives both ports and the event inputs together each cycle, first in a directed collision and then in a long pseudo-random run where both ports hit every address with random data, so collisions, re-enables after acknowledge and message overwrites all occur while a cycle-accurate model of the registers is compared against every output.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_ENSET = 4'd1;
  localparam logic [ADDR_W-1:0] A_ENCLR = 4'd2;
  localparam logic [ADDR_W-1:0] A_VEC0 = 4'd3;

  localparam int B_RAISE = 7;
  localparam int B_ALT_IRQ = 6;
  localparam int B_ALT_NMI = 4;
  localparam int B_NMI = 4;
  localparam int B_TIMER = 6;
  localparam int B_DMA = 5;
  localparam int B_CHR = 5;

  localparam logic [7:0] HOST_MASK = 8'hA0;
  localparam logic [7:0] COP_MASK = 8'hF0;
  localparam logic [7:0] COP_IRQ_MASK = 8'hE0;

  // next pending state: acknowledge first, then new raises win
  function automatic logic [7:0] next_pend(input logic [7:0] pend, input logic [7:0] clr,
                                           input logic [7:0] set, input logic [7:0] mask);
    return ((pend & ~clr) | set) & mask;
  endfunction

  function automatic logic [7:0] next_en(input logic [7:0] en, input logic [7:0] setb,
                                         input logic [7:0] clr, input logic [7:0] mask);
    return (en | setb) & ~clr & mask;
  endfunction

  function automatic logic any_active(input logic [7:0] pend, input logic [7:0] en,
                                      input logic [7:0] sel);
    return |(pend & en & sel);
  endfunction
endpackage

// File: rtl/mbx_irq_bank.sv
module mbx_irq_bank #(
  parameter logic [7:0] MASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_bits,
  input  logic [7:0] en_set,
  input  logic [7:0] clr_bits,
  output logic [7:0] pend,
  output logic [7:0] en
);
  import mbx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= next_pend(pend, clr_bits, set_bits, MASK);
      en   <= next_en(en, en_set, clr_bits, MASK);
    end
  end
endmodule

// File: rtl/mbx_vec_bank.sv
module mbx_vec_bank #(
  parameter int NV = 3,
  parameter int AW = 4,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [NV*16-1:0] vecs
);
  localparam int NB = NV * 2;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    localparam logic [AW-1:0] MY_ADDR = AW'(BASE + i);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && addr == MY_ADDR) q <= wdata;
    end
    assign vecs[i*8 +: 8] = q;
  end
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  input  logic          c_we,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_wdata,
  input  logic          chr_conv_evt,
  input  logic          timer_evt,
  input  logic          dma_done_evt,
  output logic [7:0]    h_flags,
  output logic [7:0]    c_flags,
  output logic          h_irq,
  output logic          c_irq,
  output logic          c_nmi,
  output logic [15:0]   h_alt_nmi_vec,
  output logic [15:0]   h_alt_irq_vec,
  output logic [15:0]   c_rst_vec,
  output logic [15:0]   c_nmi_vec,
  output logic [15:0]   c_irq_vec
);
  import mbx_pkg::*;

  // named write events
  logic h_ctrl_wr, h_en_wr, h_dis_wr, c_ctrl_wr, c_en_wr, c_dis_wr;
  assign h_ctrl_wr = h_we && h_addr == AW'(A_CTRL);
  assign h_en_wr   = h_we && h_addr == AW'(A_ENSET);
  assign h_dis_wr  = h_we && h_addr == AW'(A_ENCLR);
  assign c_ctrl_wr = c_we && c_addr == AW'(A_CTRL);
  assign c_en_wr   = c_we && c_addr == AW'(A_ENSET);
  assign c_dis_wr  = c_we && c_addr == AW'(A_ENCLR);

  // raise / acknowledge vectors per receiving side
  logic [7:0] h_set, h_clr, h_ens, c_set, c_clr, c_ens;
  always_comb begin
    h_set = '0;
    h_set[B_RAISE] = c_ctrl_wr && c_wdata[B_RAISE];
    h_set[B_CHR]   = chr_conv_evt;
    c_set = '0;
    c_set[B_RAISE] = h_ctrl_wr && h_wdata[B_RAISE];
    c_set[B_NMI]   = h_ctrl_wr && h_wdata[B_NMI];
    c_set[B_TIMER] = timer_evt;
    c_set[B_DMA]   = dma_done_evt;
  end
  assign h_clr = h_dis_wr ? h_wdata : 8'h00;
  assign h_ens = h_en_wr ? h_wdata : 8'h00;
  assign c_clr = c_dis_wr ? c_wdata : 8'h00;
  assign c_ens = c_en_wr ? c_wdata : 8'h00;

  logic [7:0] h_pend, h_en, c_pend, c_en;

  mbx_irq_bank #(.MASK(HOST_MASK)) u_host_bank (
    .clk(clk), .rst_n(rst_n), .set_bits(h_set), .en_set(h_ens),
    .clr_bits(h_clr), .pend(h_pend), .en(h_en)
  );

  mbx_irq_bank #(.MASK(COP_MASK)) u_cop_bank (
    .clk(clk), .rst_n(rst_n), .set_bits(c_set), .en_set(c_ens),
    .clr_bits(c_clr), .pend(c_pend), .en(c_en)
  );

  // control-register state: messages and alternate-vector selects
  logic [3:0] msg_to_cop, msg_to_host;
  logic       alt_irq_sel, alt_nmi_sel;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_to_cop  <= '0;
      msg_to_host <= '0;
      alt_irq_sel <= 1'b0;
      alt_nmi_sel <= 1'b0;
    end else begin
      if (h_ctrl_wr) msg_to_cop <= h_wdata[3:0];
      if (c_ctrl_wr) begin
        msg_to_host <= c_wdata[3:0];
        alt_irq_sel <= c_wdata[B_ALT_IRQ];
        alt_nmi_sel <= c_wdata[B_ALT_NMI];
      end
    end
  end

  assign h_flags = {h_pend[7], alt_irq_sel, h_pend[5], alt_nmi_sel, msg_to_host};
  assign c_flags = {c_pend[7:4], msg_to_cop};

  assign h_irq = any_active(h_pend, h_en, HOST_MASK);
  assign c_irq = any_active(c_pend, c_en, COP_IRQ_MASK);
  assign c_nmi = any_active(c_pend, c_en, 8'(1 << B_NMI));

  // vector storage
  logic [47:0] cop_vecs;
  logic [31:0] host_vecs;

  mbx_vec_bank #(.NV(3), .AW(AW), .BASE(AW'(A_VEC0))) u_cop_vecs (
    .clk(clk), .rst_n(rst_n), .we(h_we), .addr(h_addr), .wdata(h_wdata), .vecs(cop_vecs)
  );

  mbx_vec_bank #(.NV(2), .AW(AW), .BASE(AW'(A_VEC0))) u_host_vecs (
    .clk(clk), .rst_n(rst_n), .we(c_we), .addr(c_addr), .wdata(c_wdata), .vecs(host_vecs)
  );

  assign c_rst_vec     = cop_vecs[15:0];
  assign c_nmi_vec     = cop_vecs[31:16];
  assign c_irq_vec     = cop_vecs[47:32];
  assign h_alt_nmi_vec = host_vecs[15:0];
  assign h_alt_irq_vec = host_vecs[31:16];
endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       h_ctrl_wr,
  input logic       c_ctrl_wr,
  input logic [7:0] h_wdata,
  input logic [7:0] c_wdata,
  input logic       h_we,
  input logic [3:0] h_addr,
  input logic [7:0] h_set,
  input logic [7:0] c_set,
  input logic [7:0] h_clr,
  input logic [7:0] c_clr,
  input logic [7:0] h_en,
  input logic [7:0] h_flags,
  input logic [7:0] c_flags,
  input logic       h_irq,
  input logic       c_nmi,
  input logic [15:0] c_rst_vec
);
  AST_COP_RAISE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    c_set[7] |=> c_flags[7]);  // R2
  AST_MSG_TO_COP: assert property (@(posedge clk) disable iff (!rst_n)
    h_ctrl_wr |=> c_flags[3:0] == $past(h_wdata[3:0]));  // R2
  AST_HOST_RAISE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    h_set[7] |=> h_flags[7]);  // R3
  AST_ALT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    c_ctrl_wr |=> h_flags[6] == $past(c_wdata[6]) && h_flags[4] == $past(c_wdata[4]));  // R3
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    c_flags[7] && !c_clr[7] |=> c_flags[7]);  // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr[7] && !c_set[7] |=> !c_flags[7]);  // R5
  AST_DIS_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    h_clr[5] |=> !h_en[5]);  // R5
  AST_HIRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    h_irq |-> (h_flags[7] || h_flags[5]));  // R7
  AST_CNMI_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    c_nmi |-> c_flags[4]);  // R7
  AST_VEC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    h_we && h_addr == 4'd3 |=> c_rst_vec[7:0] == $past(h_wdata));  // R9
endmodule

bind mbx_irq_top mbx_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .h_ctrl_wr(h_ctrl_wr), .c_ctrl_wr(c_ctrl_wr),
  .h_wdata(h_wdata), .c_wdata(c_wdata), .h_we(h_we), .h_addr(h_addr),
  .h_set(h_set), .c_set(c_set), .h_clr(h_clr), .c_clr(c_clr), .h_en(h_en),
  .h_flags(h_flags), .c_flags(c_flags), .h_irq(h_irq), .c_nmi(c_nmi),
  .c_rst_vec(c_rst_vec)
);

// File: tb/sim_mbx_irq_top.sv
`timescale 1ns/100ps
module sim_mbx_irq_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_we = 1'b0, c_we = 1'b0;
  logic [3:0] h_addr = '0, c_addr = '0;
  logic [7:0] h_wdata = '0, c_wdata = '0;
  logic chr_conv_evt = 1'b0, timer_evt = 1'b0, dma_done_evt = 1'b0;
  logic [7:0] h_flags, c_flags;
  logic h_irq, c_irq, c_nmi;
  logic [15:0] h_alt_nmi_vec, h_alt_irq_vec, c_rst_vec, c_nmi_vec, c_irq_vec;

  always #2.5 clk = ~clk;

  mbx_irq_top u0 (
    .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .chr_conv_evt(chr_conv_evt),
    .timer_evt(timer_evt), .dma_done_evt(dma_done_evt), .h_flags(h_flags),
    .c_flags(c_flags), .h_irq(h_irq), .c_irq(c_irq), .c_nmi(c_nmi),
    .h_alt_nmi_vec(h_alt_nmi_vec), .h_alt_irq_vec(h_alt_irq_vec),
    .c_rst_vec(c_rst_vec), .c_nmi_vec(c_nmi_vec), .c_irq_vec(c_irq_vec)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference state, kept from the requirements
  logic [7:0] m_hp = '0, m_he = '0, m_cp = '0, m_ce = '0;
  logic [3:0] m_msg_c = '0, m_msg_h = '0;
  logic m_alt_irq = 1'b0, m_alt_nmi = 1'b0;
  logic [7:0] m_hv [0:5];
  logic [7:0] m_cv [0:3];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check_all();
    logic [7:0] ehf, ecf;
    ehf = {m_hp[7], m_alt_irq, m_hp[5], m_alt_nmi, m_msg_h};
    ecf = {m_cp[7], m_cp[6], m_cp[5], m_cp[4], m_msg_c};
    chk(h_flags == ehf, "R3 R4 R5 R8 h_flags", 48'(h_flags), 48'(ehf));
    chk(c_flags == ecf, "R2 R4 R5 R8 c_flags", 48'(c_flags), 48'(ecf));
    chk(h_irq == ((m_hp[7] & m_he[7]) | (m_hp[5] & m_he[5])), "R6 R7 h_irq",
        48'(h_irq), 48'((m_hp[7] & m_he[7]) | (m_hp[5] & m_he[5])));
    chk(c_irq == ((m_cp[7] & m_ce[7]) | (m_cp[6] & m_ce[6]) | (m_cp[5] & m_ce[5])), "R6 R7 c_irq",
        48'(c_irq), 48'((m_cp[7] & m_ce[7]) | (m_cp[6] & m_ce[6]) | (m_cp[5] & m_ce[5])));
    chk(c_nmi == (m_cp[4] & m_ce[4]), "R7 c_nmi", 48'(c_nmi), 48'(m_cp[4] & m_ce[4]));
    chk({c_irq_vec, c_nmi_vec, c_rst_vec} == {m_hv[5], m_hv[4], m_hv[3], m_hv[2], m_hv[1], m_hv[0]},
        "R9 cop vectors", {c_irq_vec, c_nmi_vec, c_rst_vec},
        {m_hv[5], m_hv[4], m_hv[3], m_hv[2], m_hv[1], m_hv[0]});
    chk({h_alt_irq_vec, h_alt_nmi_vec} == {m_cv[3], m_cv[2], m_cv[1], m_cv[0]},
        "R9 alt vectors", 48'({h_alt_irq_vec, h_alt_nmi_vec}), 48'({m_cv[3], m_cv[2], m_cv[1], m_cv[0]}));
  endtask

  // one cycle on both ports plus events; model follows, then outputs are compared
  task automatic cyc(input logic hwe, input logic [3:0] ha, input logic [7:0] hd,
                     input logic cwe, input logic [3:0] ca, input logic [7:0] cd,
                     input logic chr, input logic tim, input logic dma);
    logic [7:0] hs, cs, hc, cc;
    h_we = hwe; h_addr = ha; h_wdata = hd;
    c_we = cwe; c_addr = ca; c_wdata = cd;
    chr_conv_evt = chr; timer_evt = tim; dma_done_evt = dma;
    hs = {cwe && ca == 0 && cd[7], 1'b0, chr, 5'b0};
    cs = {hwe && ha == 0 && hd[7], tim, dma, hwe && ha == 0 && hd[4], 4'b0};
    hc = (hwe && ha == 2) ? hd : 8'h00;
    cc = (cwe && ca == 2) ? cd : 8'h00;
    m_hp = ((m_hp & ~hc) | hs) & 8'hA0;
    m_cp = ((m_cp & ~cc) | cs) & 8'hF0;
    if (hwe && ha == 1) m_he = m_he | hd;
    if (cwe && ca == 1) m_ce = m_ce | cd;
    m_he = m_he & ~hc & 8'hA0;
    m_ce = m_ce & ~cc & 8'hF0;
    if (hwe && ha == 0) m_msg_c = hd[3:0];
    if (cwe && ca == 0) begin
      m_msg_h = cd[3:0]; m_alt_irq = cd[6]; m_alt_nmi = cd[4];
    end
    if (hwe && ha >= 3 && ha <= 8) m_hv[ha - 3] = hd;
    if (cwe && ca >= 3 && ca <= 6) m_cv[ca - 3] = cd;
    @(posedge clk);
    #1;
    check_all();
    @(negedge clk);
    h_we = 1'b0; c_we = 1'b0; chr_conv_evt = 1'b0; timer_evt = 1'b0; dma_done_evt = 1'b0;
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 4'd0, 8'd0, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic cw(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b0, 4'd0, 8'd0, 1'b1, a, d, 1'b0, 1'b0, 1'b0);
  endtask
  task automatic idle();
    cyc(1'b0, 4'd0, 8'd0, 1'b0, 4'd0, 8'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) m_hv[i] = '0;
    for (int i = 0; i < 4; i++) m_cv[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(h_flags == 8'h00 && c_flags == 8'h00, "R1 flags", 48'({h_flags, c_flags}), 48'h0);
    chk({h_irq, c_irq, c_nmi} == 3'b000, "R1 irq lines", 48'({h_irq, c_irq, c_nmi}), 48'h0);
    chk(c_rst_vec == 0 && c_irq_vec == 0 && h_alt_irq_vec == 0, "R1 vectors",
        48'({c_rst_vec, c_irq_vec, h_alt_irq_vec}), 48'h0);
    check_all();

    // R2 / R3 exhaustive message nibble sweeps
    for (int v = 0; v < 16; v++) hw(4'd0, 8'(v));
    for (int v = 0; v < 64; v++) cw(4'd0, {1'b0, v[5], 1'b0, v[4], v[3:0]});

    // R4 sticky pending through zero writes, then R7 enable
    hw(4'd0, 8'h80);
    for (int k = 0; k < 4; k++) hw(4'd0, 8'h05);
    chk(c_flags[7] == 1'b1, "R4 sticky cop irq", 48'(c_flags[7]), 48'h1);
    cw(4'd1, 8'h80);
    chk(c_irq == 1'b1, "R7 c_irq after enable", 48'(c_irq), 48'h1);
    cw(4'd2, 8'h80);
    chk(c_flags[7] == 1'b0 && c_irq == 1'b0, "R5 ack clears", 48'({c_flags[7], c_irq}), 48'h0);

    // R6 unimplemented enable bits ignored; NMI path
    cw(4'd1, 8'h1F);
    hw(4'd0, 8'h10);
    chk(c_nmi == 1'b1 && c_irq == 1'b0, "R6 R7 nmi only", 48'({c_nmi, c_irq}), 48'h2);
    hw(4'd1, 8'h5F);
    cw(4'd0, 8'h80);
    chk(h_irq == 1'b0, "R6 host bit7 not enabled", 48'(h_irq), 48'h0);

    // R5 same-cycle raise and acknowledge: raise wins, enable cleared
    cw(4'd1, 8'h80);
    cyc(1'b1, 4'd0, 8'h80, 1'b1, 4'd2, 8'h80, 1'b0, 1'b0, 1'b0);
    chk(c_flags[7] == 1'b1 && c_irq == 1'b0, "R5 raise beats ack", 48'({c_flags[7], c_irq}), 48'h2);

    // R8 events, including event against acknowledge
    cyc(1'b0, 4'd0, 8'd0, 1'b0, 4'd0, 8'd0, 1'b1, 1'b1, 1'b1);
    chk(h_flags[5] && c_flags[6] && c_flags[5], "R8 events set flags",
        48'({h_flags[5], c_flags[6], c_flags[5]}), 48'h7);
    cyc(1'b0, 4'd0, 8'd0, 1'b1, 4'd2, 8'h60, 1'b0, 1'b1, 1'b0);
    chk(c_flags[6:5] == 2'b10, "R8 R5 timer vs ack", 48'(c_flags[6:5]), 48'h2);

    // R9 vectors every byte
    for (int a = 3; a <= 8; a++) hw(4'(a), 8'(a * 37));
    for (int a = 3; a <= 6; a++) cw(4'(a), 8'(a * 53));
    chk(c_irq_vec == {8'(8 * 37), 8'(7 * 37)}, "R9 irq vector order", 48'(c_irq_vec),
        48'({8'(8 * 37), 8'(7 * 37)}));

    // pseudo-random run on both ports
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1, r2;
      seed = rnd(seed); r1 = seed;
      seed = rnd(seed); r2 = seed;
      cyc(r1[0], 4'(r1[7:4] % 9), r1[15:8], r2[0], 4'(r2[7:4] % 7), r2[15:8],
          r1[20] & r1[21], r2[20] & r2[21], r1[22] & r2[22]);
      if (n % 500 == 250) idle();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule